// File: doc/BRIEF.md
# Pipelined Synchronous Burst SRAM

A clocked static memory of 18-bit words for a pipelined host bus. Each word holds two 9-bit byte lanes. In each lane, bits 7:0 of the lane are data and bit 8 is parity, stored like any other bit. Lane 0 sits on word bits 8:0 and lane 1 on bits 17:9. A request is registered on one clock edge. The memory is read between that edge and the next, and the result is held in an output register. The data therefore reaches the bus one edge after the request edge. A write is also carried out from registered address, lane and data values, on the edge after the one that captured it.

Two active-low start strobes can open a four-beat burst. The processor-side strobe always starts a read. The controller-side strobe starts a read or a write, chosen by the write inputs it sees in the same cycle. Once a burst is open, a cycle with chip select low and both strobes high continues it. A continue cycle reads or writes, depending on the write inputs. The two low address bits step forward only while the advance input is low, either in linear order (modulo 4) or in interleaved order (start bits XOR beat number). The output bus is driven only while a registered read result is pending and the output enable is low. A deselect cycle releases the bus after a single output cycle.

Top module: `sync_burst_sram`

## Requirements
- R1: After reset, with output enable low and chip select high, the bus is not driven (`dq_oe` = 0).
- R2: A cycle with `sel_n`=0, `host_start_n`=0 and `cpu_start_n`=1 captures `addr` and `din` and writes the word when any write input is low; a later read returns it.
- R3: A cycle with `sel_n`=0 and `cpu_start_n`=0 always reads, whatever the write inputs. A write on that path needs a following continue cycle with write inputs low, and that cycle writes the held address when `burst_next_n`=1.
- R4: Read data whose address was captured at edge k is not on the bus after edge k, and is on `dq` with `dq_oe`=1 after edge k+1.
- R5: With `order_xor`=0, beat n of a burst from address B uses low bits (B[1:0]+n) mod 4. Address bits above bit 1 stay at B's value for all four beats.
- R6: With `order_xor`=1, beat n of a burst from address B uses low bits B[1:0] XOR n.
- R7: A continue cycle with `burst_next_n`=1 accesses the same address as the previous access.
- R8: `lane_wr_n[0]` low writes word bits 8:0 and `lane_wr_n[1]` low writes bits 17:9. A lane whose enable is high keeps its stored content.
- R9: `write_all_n` low writes both lanes, even with both `lane_wr_n` bits high.
- R10: If a read at edge k is followed by chip select high at edge k+1, data is driven after k+1 and the bus is released after edge k+2.
- R11: `out_en_n` gates the bus combinationally: `dq_oe` follows it with no clock edge in between.
- R12: A cycle with `sel_n`=1 performs no access, even with strobes and write inputs low: memory is unchanged and no read result follows.
- R13: When both strobes are low in the same cycle, the processor-side strobe wins, so the cycle reads and writes nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all inputs sampled on its rising edge |
| rst_n | input | 1 | Active-low reset of control registers |
| sel_n | input | 1 | Active-low chip select; high makes the cycle a deselect |
| cpu_start_n | input | 1 | Active-low processor-side burst start (read only) |
| host_start_n | input | 1 | Active-low controller-side burst start (read or write) |
| burst_next_n | input | 1 | Active-low advance of the burst address on continue cycles |
| order_xor | input | 1 | Burst order: 1 interleaved, 0 linear |
| addr | input | ADDR_W | Word address, taken on start cycles |
| din | input | LANES*LANE_W | Write data |
| lane_wr_n | input | LANES | Active-low per-lane write enables |
| write_all_n | input | 1 | Active-low write of every lane |
| out_en_n | input | 1 | Active-low combinational output enable |
| dq | output | LANES*LANE_W | Read data, high-impedance when not driven |
| dq_oe | output | 1 | High while `dq` is driven |

## Verification
The bench writes distinct words into a group of four addresses. It then reads them back as bursts in both orders from unaligned start addresses. A design with the wrong order, or one that carried into bit 2, returns words out of sequence. Held-advance cycles are checked to repeat a word, where a design that stepped anyway would return the next one. Partial-lane writes over a full word catch a lane enable that spills into the other lane or ignores the global write. A write attempted on the processor-side start is checked to leave memory alone and return the old word, while the following continue cycle must write. Cycles with both strobes low, or with chip select high, must leave memory untouched. The bench checks when the bus is released after a deselect, and catches a design that held data for an extra cycle or dropped it a cycle early.

// File: rtl/sburst_pkg.sv
package sburst_pkg;

  // Low address bits used for burst sequencing
  localparam int BEAT_W = 2;

  typedef enum logic [1:0] {
    ACC_IDLE = 2'd0,
    ACC_RD   = 2'd1,
    ACC_WR   = 2'd2
  } acc_e;

  // Low bits of the address for a given beat of a burst
  function automatic logic [BEAT_W-1:0] burst_low(
    input logic [BEAT_W-1:0] start_low,
    input logic [BEAT_W-1:0] beat,
    input logic              xor_mode
  );
    if (xor_mode) return start_low ^ beat;
    return start_low + beat;
  endfunction

endpackage

// File: rtl/sburst_beat_ctr.sv
module sburst_beat_ctr
  import sburst_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              step,
  input  logic              xor_mode,
  input  logic [BEAT_W-1:0] load_low,
  output logic [BEAT_W-1:0] next_low
);

  logic [BEAT_W-1:0] start_q;
  logic [BEAT_W-1:0] beat_q;
  logic [BEAT_W-1:0] beat_inc;

  assign beat_inc = beat_q + BEAT_W'(1);
  assign next_low = burst_low(start_q, beat_inc, xor_mode);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start_q <= '0;
      beat_q  <= '0;
    end else if (load) begin
      start_q <= load_low;
      beat_q  <= '0;
    end else if (step) begin
      beat_q <= beat_inc;
    end
  end

  // R5
  beat_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !load) |=> beat_q == BEAT_W'($past(beat_q) + 1'b1));

endmodule

// File: rtl/sburst_addr_stage.sv
module sburst_addr_stage
  import sburst_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int LANES  = 2,
  parameter int LANE_W = 9,
  localparam int WORD_W = LANES * LANE_W
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel_n,
  input  logic              cpu_start_n,
  input  logic              host_start_n,
  input  logic              burst_next_n,
  input  logic              order_xor,
  input  logic [ADDR_W-1:0] addr,
  input  logic [WORD_W-1:0] din,
  input  logic [LANES-1:0]  lane_wr_n,
  input  logic              write_all_n,
  output logic              acc_valid,
  output logic              acc_write,
  output logic [ADDR_W-1:0] acc_addr,
  output logic [LANES-1:0]  acc_lanes,
  output logic [WORD_W-1:0] acc_data
);

  // Named cycle events
  logic start_cpu, start_host, cont, adv_step, wr_req;
  logic [LANES-1:0]  lane_req;
  logic [BEAT_W-1:0] next_low;
  logic [ADDR_W-1:0] nxt_addr;
  acc_e              kind;

  assign start_cpu  = !sel_n && !cpu_start_n;
  assign start_host = !sel_n && cpu_start_n && !host_start_n;
  assign cont       = !sel_n && cpu_start_n && host_start_n;
  assign adv_step   = cont && !burst_next_n;

  for (genvar g = 0; g < LANES; g++) begin : g_lane_req
    assign lane_req[g] = !write_all_n || !lane_wr_n[g];
  end
  assign wr_req = |lane_req;

  always_comb begin
    if (start_cpu)                kind = ACC_RD;
    else if (start_host || cont)  kind = wr_req ? ACC_WR : ACC_RD;
    else                          kind = ACC_IDLE;
  end

  always_comb begin
    if (start_cpu || start_host) nxt_addr = addr;
    else if (adv_step)           nxt_addr = {acc_addr[ADDR_W-1:BEAT_W], next_low};
    else                         nxt_addr = acc_addr;
  end

  sburst_beat_ctr u_ctr (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (start_cpu || start_host),
    .step     (adv_step),
    .xor_mode (order_xor),
    .load_low (addr[BEAT_W-1:0]),
    .next_low (next_low)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_valid <= 1'b0;
      acc_write <= 1'b0;
      acc_addr  <= '0;
      acc_lanes <= '0;
      acc_data  <= '0;
    end else begin
      acc_valid <= (kind != ACC_IDLE);
      acc_write <= (kind == ACC_WR);
      acc_lanes <= (kind == ACC_WR) ? lane_req : '0;
      if (kind != ACC_IDLE) acc_addr <= nxt_addr;
      if (kind == ACC_WR)   acc_data <= din;
    end
  end

  // R3
  cpu_start_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_cpu |=> acc_valid && !acc_write);

  // R13
  cpu_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!sel_n && !cpu_start_n && !host_start_n) |=> !acc_write);

  // R12
  deselect_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sel_n |=> !acc_valid);

  // R9
  global_all_lanes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start_host && !write_all_n) |=> acc_write && (&acc_lanes));

  // R7
  hold_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cont && burst_next_n) |=> $stable(acc_addr));

  // R5
  upper_fixed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cont |=> acc_addr[ADDR_W-1:BEAT_W] == $past(acc_addr[ADDR_W-1:BEAT_W]));

  // R5
  linear_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (adv_step && !order_xor) |=>
      acc_addr[BEAT_W-1:0] == BEAT_W'($past(acc_addr[BEAT_W-1:0]) + 1'b1));

endmodule

// File: rtl/sburst_lane_mem.sv
module sburst_lane_mem #(
  parameter int ADDR_W = 8,
  parameter int LANES  = 2,
  parameter int LANE_W = 9,
  localparam int WORD_W = LANES * LANE_W,
  localparam int DEPTH  = 1 << ADDR_W
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [LANES-1:0]  wr_lane,
  input  logic [ADDR_W-1:0] addr,
  input  logic [WORD_W-1:0] wdata,
  output logic [WORD_W-1:0] rdata
);

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LANE_W-1:0] cells [DEPTH];

    always_ff @(posedge clk) begin
      if (wr_lane[g]) cells[addr] <= wdata[g*LANE_W +: LANE_W];
    end

    assign rdata[g*LANE_W +: LANE_W] = cells[addr];

    // R8
    lane_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_lane[g] |=> (addr != $past(addr)) ||
        (rdata[g*LANE_W +: LANE_W] == $past(wdata[g*LANE_W +: LANE_W])));
  end

endmodule

// File: rtl/sburst_out_stage.sv
module sburst_out_stage #(
  parameter int WORD_W = 18
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_fire,
  input  logic [WORD_W-1:0] rd_word,
  input  logic              out_en_n,
  output logic [WORD_W-1:0] dq,
  output logic              dq_oe
);

  logic              q_valid;
  logic [WORD_W-1:0] q_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_valid <= 1'b0;
      q_data  <= '0;
    end else begin
      q_valid <= rd_fire;
      if (rd_fire) q_data <= rd_word;
    end
  end

  assign dq_oe = q_valid && !out_en_n;
  assign dq    = dq_oe ? q_data : {WORD_W{1'bz}};

  // R4
  read_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_fire |=> q_valid && (q_data == $past(rd_word)));

endmodule

// File: rtl/sync_burst_sram.sv
module sync_burst_sram #(
  parameter int ADDR_W = 8,
  parameter int LANES  = 2,
  parameter int LANE_W = 9,
  localparam int WORD_W = LANES * LANE_W
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel_n,
  input  logic              cpu_start_n,
  input  logic              host_start_n,
  input  logic              burst_next_n,
  input  logic              order_xor,
  input  logic [ADDR_W-1:0] addr,
  input  logic [WORD_W-1:0] din,
  input  logic [LANES-1:0]  lane_wr_n,
  input  logic              write_all_n,
  input  logic              out_en_n,
  output logic [WORD_W-1:0] dq,
  output logic              dq_oe
);

  logic              acc_valid, acc_write, rd_fire;
  logic [ADDR_W-1:0] acc_addr;
  logic [LANES-1:0]  acc_lanes, mem_wr;
  logic [WORD_W-1:0] acc_data, rd_word;

  sburst_addr_stage #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_addr (
    .clk          (clk),
    .rst_n        (rst_n),
    .sel_n        (sel_n),
    .cpu_start_n  (cpu_start_n),
    .host_start_n (host_start_n),
    .burst_next_n (burst_next_n),
    .order_xor    (order_xor),
    .addr         (addr),
    .din          (din),
    .lane_wr_n    (lane_wr_n),
    .write_all_n  (write_all_n),
    .acc_valid    (acc_valid),
    .acc_write    (acc_write),
    .acc_addr     (acc_addr),
    .acc_lanes    (acc_lanes),
    .acc_data     (acc_data)
  );

  assign mem_wr  = acc_lanes & {LANES{acc_valid && acc_write}};
  assign rd_fire = acc_valid && !acc_write;

  sburst_lane_mem #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_mem (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_lane (mem_wr),
    .addr    (acc_addr),
    .wdata   (acc_data),
    .rdata   (rd_word)
  );

  sburst_out_stage #(.WORD_W(WORD_W)) u_out (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_fire  (rd_fire),
    .rd_word  (rd_word),
    .out_en_n (out_en_n),
    .dq       (dq),
    .dq_oe    (dq_oe)
  );

  // R10
  deselect_hiz_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sel_n |-> ##2 !dq_oe);

endmodule

// File: tb/tb_sync_burst_sram.sv
module tb_sync_burst_sram;
  localparam int CLK_P = 10;
  localparam int AW = 8;
  localparam int NL = 2;
  localparam int LW = 9;
  localparam int DW = NL * LW;

  logic clk = 1'b0;
  always #(CLK_P/2) clk = ~clk;

  logic          rst_n, sel_n, cpu_start_n, host_start_n, burst_next_n, order_xor;
  logic [AW-1:0] addr;
  logic [DW-1:0] din;
  logic [NL-1:0] lane_wr_n;
  logic          write_all_n, out_en_n;
  logic [DW-1:0] dq;
  logic          dq_oe;

  sync_burst_sram #(.ADDR_W(AW), .LANES(NL), .LANE_W(LW)) dut (
    .clk(clk), .rst_n(rst_n), .sel_n(sel_n), .cpu_start_n(cpu_start_n),
    .host_start_n(host_start_n), .burst_next_n(burst_next_n), .order_xor(order_xor),
    .addr(addr), .din(din), .lane_wr_n(lane_wr_n), .write_all_n(write_all_n),
    .out_en_n(out_en_n), .dq(dq), .dq_oe(dq_oe)
  );

  int checks = 0;
  int errors = 0;
  logic [DW-1:0] model [1 << AW];

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic go_idle();
    sel_n = 1'b1; cpu_start_n = 1'b1; host_start_n = 1'b1; burst_next_n = 1'b1;
    lane_wr_n = '1; write_all_n = 1'b1;
  endtask

  task automatic check_bit(string req, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0b expected=%0b", req, act, exp);
    end
  endtask

  task automatic expect_out(string req, logic [DW-1:0] exp);
    checks++;
    if (dq_oe !== 1'b1 || dq !== exp) begin
      errors++;
      $display("FAIL %s: actual oe=%0b data=%h expected oe=1 data=%h", req, dq_oe, dq, exp);
    end
  endtask

  // Burst address by beat, restated from R5/R6
  function automatic logic [AW-1:0] beat_addr(logic [AW-1:0] b, int n, logic xm);
    logic [1:0] lo;
    if (xm) lo = b[1:0] ^ 2'(n);
    else    lo = 2'((int'(b[1:0]) + n) % 4);
    return {b[AW-1:2], lo};
  endfunction

  task automatic write_one(logic [AW-1:0] a, logic [DW-1:0] d, logic [NL-1:0] ln, logic alln);
    sel_n = 1'b0; host_start_n = 1'b0; addr = a; din = d; lane_wr_n = ln; write_all_n = alln;
    step();
    go_idle();
    step();
    for (int i = 0; i < NL; i++)
      if (!alln || !ln[i]) model[a][i*LW +: LW] = d[i*LW +: LW];
  endtask

  task automatic read_one(string req, logic [AW-1:0] a);
    sel_n = 1'b0; cpu_start_n = 1'b0; addr = a;
    step();
    check_bit("R4 not driven after request edge", dq_oe, 1'b0);
    go_idle();
    step();
    expect_out(req, model[a]);
    step();
    check_bit("R10 released after deselect", dq_oe, 1'b0);
  endtask

  task automatic t_reset();
    check_bit("R1 idle after reset", dq_oe, 1'b0);
    step();
    check_bit("R1 idle after reset", dq_oe, 1'b0);
  endtask

  task automatic t_basic();
    write_one(8'h10, 18'h2A5C3, 2'b11, 1'b0);
    read_one("R2 host write then read", 8'h10);
    write_one(8'h11, 18'h1B7E4, 2'b00, 1'b1);
    read_one("R2 write by both lanes", 8'h11);
  endtask

  task automatic t_lanes();
    write_one(8'h20, 18'h3FFFF, 2'b11, 1'b0);
    write_one(8'h20, 18'h00000, 2'b10, 1'b1);
    read_one("R8 lane0 only, bits 8:0", 8'h20);
    write_one(8'h20, 18'h12345, 2'b01, 1'b1);
    read_one("R8 lane1 only, bits 17:9", 8'h20);
    write_one(8'h20, 18'h0A0A5, 2'b11, 1'b0);
    read_one("R9 global overrides lane enables", 8'h20);
  endtask

  task automatic t_cpu_write();
    write_one(8'h30, 18'h11111, 2'b11, 1'b0);
    sel_n = 1'b0; cpu_start_n = 1'b0; addr = 8'h30; din = 18'h22222; write_all_n = 1'b0;
    step();
    cpu_start_n = 1'b1; burst_next_n = 1'b1; din = 18'h33333; write_all_n = 1'b0;
    step();
    expect_out("R3 cpu start reads old word", 18'h11111);
    go_idle();
    step();
    model[8'h30] = 18'h33333;
    read_one("R3 follow-up cycle writes held address", 8'h30);
  endtask

  task automatic t_priority();
    write_one(8'h38, 18'h0F0F0, 2'b11, 1'b0);
    sel_n = 1'b0; cpu_start_n = 1'b0; host_start_n = 1'b0; addr = 8'h38;
    din = 18'h3C3C3; write_all_n = 1'b0;
    step();
    go_idle();
    step();
    expect_out("R13 both strobes read", 18'h0F0F0);
    step();
    read_one("R13 both strobes leave memory", 8'h38);
  endtask

  task automatic t_ce();
    write_one(8'h3C, 18'h05AF0, 2'b11, 1'b0);
    sel_n = 1'b1; host_start_n = 1'b0; cpu_start_n = 1'b1; addr = 8'h3C;
    din = 18'h3FA50; write_all_n = 1'b0; lane_wr_n = 2'b00;
    step();
    go_idle();
    step();
    check_bit("R12 no read result after deselect", dq_oe, 1'b0);
    read_one("R12 deselected write ignored", 8'h3C);
  endtask

  task automatic t_burst_rd(logic [AW-1:0] b, logic xm, string req);
    for (int i = 0; i < 4; i++)
      write_one({b[AW-1:2], 2'(i)}, 18'h04000 + 18'(b) * 18'd16 + 18'(i), 2'b11, 1'b0);
    order_xor = xm;
    sel_n = 1'b0; cpu_start_n = 1'b0; addr = b;
    step();
    cpu_start_n = 1'b1; burst_next_n = 1'b0;
    for (int n = 1; n < 4; n++) begin
      step();
      expect_out(req, model[beat_addr(b, n - 1, xm)]);
    end
    go_idle();
    step();
    expect_out(req, model[beat_addr(b, 3, xm)]);
    step();
    check_bit("R10 released after burst", dq_oe, 1'b0);
  endtask

  task automatic t_burst_wr(logic [AW-1:0] b, logic xm, string req);
    for (int i = 0; i < 4; i++)
      write_one({b[AW-1:2], 2'(i)}, 18'h0, 2'b11, 1'b0);
    order_xor = xm;
    sel_n = 1'b0; host_start_n = 1'b0; addr = b; write_all_n = 1'b0;
    din = 18'h2B000 + 18'(b);
    step();
    host_start_n = 1'b1; burst_next_n = 1'b0;
    model[beat_addr(b, 0, xm)] = din;
    for (int n = 1; n < 4; n++) begin
      din = 18'h2B000 + 18'(b) + 18'(n) * 18'h100;
      model[beat_addr(b, n, xm)] = din;
      step();
    end
    go_idle();
    step();
    for (int i = 0; i < 4; i++)
      read_one(req, {b[AW-1:2], 2'(i)});
  endtask

  task automatic t_hold();
    for (int i = 0; i < 4; i++)
      write_one({6'h20, 2'(i)}, 18'h19000 + 18'(i), 2'b11, 1'b0);
    order_xor = 1'b0;
    sel_n = 1'b0; cpu_start_n = 1'b0; addr = 8'h81;
    step();
    cpu_start_n = 1'b1; burst_next_n = 1'b1;
    step();
    expect_out("R7 held advance", model[8'h81]);
    step();
    expect_out("R7 held advance", model[8'h81]);
    burst_next_n = 1'b0;
    step();
    expect_out("R7 held advance", model[8'h81]);
    go_idle();
    step();
    expect_out("R7 step after hold", model[8'h82]);
    step();
  endtask

  task automatic t_oe();
    write_one(8'h44, 18'h1D2E3, 2'b11, 1'b0);
    sel_n = 1'b0; cpu_start_n = 1'b0; addr = 8'h44;
    step();
    go_idle();
    step();
    expect_out("R11 driven with enable low", model[8'h44]);
    #1 out_en_n = 1'b1;
    #1 check_bit("R11 enable high releases bus", dq_oe, 1'b0);
    out_en_n = 1'b0;
    #1 expect_out("R11 enable low drives again", model[8'h44]);
    step();
  endtask

  initial begin
    #(CLK_P * 100000);
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    rst_n = 1'b0; out_en_n = 1'b0; order_xor = 1'b0; addr = '0; din = '0;
    go_idle();
    repeat (3) step();
    rst_n = 1'b1;
    t_reset();
    t_basic();
    t_lanes();
    t_cpu_write();
    t_priority();
    t_ce();
    t_burst_rd(8'h42, 1'b0, "R5 linear burst read");
    t_burst_rd(8'h53, 1'b1, "R6 interleaved burst read");
    t_burst_wr(8'h61, 1'b1, "R6 interleaved burst write");
    t_burst_wr(8'h73, 1'b0, "R5 linear burst write");
    t_hold();
    t_oe();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule